// File: doc/BRIEF.md
# Indexed-Access Multi-CPU Interrupt Controller

This block collects level interrupt lines and presents each processor of a small multiprocessor cluster with one interrupt output and one acknowledge value. Software never rewrites a whole bitmap. To turn a source on or off it writes that source's index to a set register or to a clear register.

The lowest sources (indices 0 to 28) are private to each processor. Each processor has its own mask bit for each of them. The remaining sources are shared. A single global enable gates a shared source, and a per-source routing field decides which processors see it.

Each processor reads its acknowledge register. The register returns the lowest-numbered source that currently qualifies for that processor, or a spurious code of 1023 when no source qualifies. Reading has no side effect, and a source stays pending only as long as its input line is high. Indices 0 and 1 are conventionally wired to doorbell summary lines: 0 for inter-processor doorbells and 1 for message doorbells. Here they are ordinary private sources.

Top module: `mcic_top`

## Requirements
- R1: After reset every private mask bit is set, every global enable and routing field is zero, every `cpu_irq` bit is low, and every acknowledge read returns 1023.
- R2: A read of address 0x000 returns the number of implemented sources `NUM_SRC` in bits [11:2], with every other bit zero.
- R3: Writing a shared source index to address 0x030 sets its global enable, and writing it to 0x034 clears the enable. An index of `NUM_SRC` or more leaves all state unchanged.
- R4: Writing a private index (0 to 28) to 0x048 masks that source for the accessing processor (`acc_cpu`), and writing it to 0x04C unmasks it. Other processors are unaffected, and mask writes with a shared index change nothing.
- R5: A private source qualifies for processor c when its input is high and c's mask bit for it is clear. Global enable and routing writes for a private index have no effect on it.
- R6: A shared source n qualifies for processor c only when its input is high, its enable is set and bit c of its routing field is set. The routing field sits in bits [NUM_CPU-1:0] of the register at 0x100 + 4*n; it is read back there, and its upper bits read as zero.
- R7: A read of 0x044 returns, for the accessing processor, the lowest-numbered qualifying source in bits [9:0], or 1023 when none qualifies. Bits [31:10] are zero.
- R8: `cpu_irq[c]` is high exactly when processor c's acknowledge value differs from 1023.
- R9: An input change sampled at a clock edge, or a write taking effect at an edge, shows in `cpu_irq` and in the acknowledge value after the next edge. Read data appears on `rdata` after the edge that samples `rd_en`.
- R10: Sources are level sensitive. When an input falls, it stops qualifying after the next edge; nothing is latched.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 12 | Byte address of the register |
| acc_cpu | input | CPU_W | Processor issuing the access; selects the private mask bank and acknowledge view |
| wdata | input | 32 | Write data (source index or routing field) |
| rdata | output | 32 | Registered read data, zero when no read was sampled |
| irq_src | input | NUM_SRC | Level interrupt inputs, one per source |
| cpu_irq | output | NUM_CPU | Interrupt request to each processor |

## Verification
A write takes effect at the edge that samples it. The registered acknowledge values follow one edge later. A read returns the acknowledge state held before its own sampling edge.

The bench therefore checks `cpu_irq` at the falling edge right after a write edge, where the old value is still expected. It checks again one cycle later, where the new value is due.

Input changes are driven at a falling edge and their effect is checked one full cycle later. Reads are issued no earlier than the cycle after the acknowledge update. A scoreboard pops the expected word at the falling edge following the read's sampling edge.

// File: rtl/mcic_pkg.sv
package mcic_pkg;

    localparam int unsigned    ID_W        = 10;
    localparam logic [ID_W-1:0] SPURIOUS_ID = 10'd1023;

    localparam logic [11:0] OFS_INFO    = 12'h000;
    localparam logic [11:0] OFS_EN_SET  = 12'h030;
    localparam logic [11:0] OFS_EN_CLR  = 12'h034;
    localparam logic [11:0] OFS_ACK     = 12'h044;
    localparam logic [11:0] OFS_MSK_SET = 12'h048;
    localparam logic [11:0] OFS_MSK_CLR = 12'h04C;
    localparam logic [11:0] OFS_ROUTE   = 12'h100;

    typedef enum logic [2:0] {
        OP_NONE,
        OP_EN_SET,
        OP_EN_CLR,
        OP_MSK_SET,
        OP_MSK_CLR,
        OP_ROUTE
    } wr_op_e;

endpackage

// File: rtl/mcic_decode.sv
module mcic_decode
    import mcic_pkg::*;
#(
    parameter int unsigned NUM_SRC = 64
) (
    input  logic                       wr_en,
    input  logic [11:0]                addr,
    input  logic [31:0]                wdata,
    output wr_op_e                     op,
    output logic [$clog2(NUM_SRC)-1:0] idx,
    output logic                       rt_hit,
    output logic [$clog2(NUM_SRC)-1:0] rt_idx
);

    localparam int unsigned     SRC_W = $clog2(NUM_SRC);
    localparam logic [ID_W-1:0] LIM   = ID_W'(NUM_SRC);

    logic [ID_W-1:0] wr_idx;
    logic [11:0]     rt_off;
    logic            idx_ok;
    logic            unused_hi;

    assign wr_idx    = wdata[ID_W-1:0];
    assign idx_ok    = wr_idx < LIM;
    assign unused_hi = ^wdata[31:ID_W];
    assign rt_off    = addr - OFS_ROUTE;
    assign rt_hit    = (addr >= OFS_ROUTE) && (addr[1:0] == 2'b00) && (rt_off[11:2] < LIM);
    assign rt_idx    = rt_off[SRC_W+1:2];

    always_comb begin
        op  = OP_NONE;
        idx = wr_idx[SRC_W-1:0];
        if (wr_en) begin
            case (addr)
                OFS_EN_SET:  if (idx_ok) op = OP_EN_SET;
                OFS_EN_CLR:  if (idx_ok) op = OP_EN_CLR;
                OFS_MSK_SET: if (idx_ok) op = OP_MSK_SET;
                OFS_MSK_CLR: if (idx_ok) op = OP_MSK_CLR;
                default: begin
                    if (rt_hit) begin
                        op  = OP_ROUTE;
                        idx = rt_idx;
                    end
                end
            endcase
        end
    end

endmodule

// File: rtl/mcic_state.sv
module mcic_state
    import mcic_pkg::*;
#(
    parameter int unsigned NUM_SRC = 64,
    parameter int unsigned NUM_CPU = 4,
    parameter int unsigned PC_N    = 29,
    localparam int unsigned SRC_W  = $clog2(NUM_SRC),
    localparam int unsigned CPU_W  = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  wr_op_e                           op,
    input  logic [SRC_W-1:0]                 idx,
    input  logic [CPU_W-1:0]                 wr_cpu,
    input  logic [NUM_CPU-1:0]               rt_wdata,
    output logic [NUM_SRC-1:0]               gen_en,
    output logic [NUM_CPU-1:0][PC_N-1:0]     mask,
    output logic [NUM_SRC-1:0][NUM_CPU-1:0]  route
);

    typedef struct packed {
        logic [NUM_SRC-1:0]              en;
        logic [NUM_CPU-1:0][PC_N-1:0]    msk;
        logic [NUM_SRC-1:0][NUM_CPU-1:0] rt;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        case (op)
            OP_EN_SET: st_d.en[idx] = 1'b1;
            OP_EN_CLR: st_d.en[idx] = 1'b0;
            OP_MSK_SET, OP_MSK_CLR: begin
                for (int c = 0; c < NUM_CPU; c++) begin
                    for (int s = 0; s < PC_N; s++) begin
                        if ((wr_cpu == CPU_W'(c)) && (idx == SRC_W'(s))) begin
                            st_d.msk[c][s] = (op == OP_MSK_SET);
                        end
                    end
                end
            end
            OP_ROUTE: st_d.rt[idx] = rt_wdata;
            default: ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.en  <= '0;
            st_q.msk <= '1;
            st_q.rt  <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign gen_en = st_q.en;
    assign mask   = st_q.msk;
    assign route  = st_q.rt;

endmodule

// File: rtl/mcic_pick.sv
module mcic_pick
    import mcic_pkg::*;
#(
    parameter int unsigned NUM_SRC = 64
) (
    input  logic [NUM_SRC-1:0] pend,
    output logic [ID_W-1:0]    id
);

    always_comb begin
        id = SPURIOUS_ID;
        for (int s = NUM_SRC - 1; s >= 0; s--) begin
            if (pend[s]) begin
                id = ID_W'(s);
            end
        end
    end

endmodule

// File: rtl/mcic_top.sv
module mcic_top
    import mcic_pkg::*;
#(
    parameter int unsigned NUM_SRC    = 64,
    parameter int unsigned NUM_CPU    = 4,
    parameter int unsigned LOCAL_LAST = 28,
    localparam int unsigned CPU_W     = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic               rd_en,
    input  logic [11:0]        addr,
    input  logic [CPU_W-1:0]   acc_cpu,
    input  logic [31:0]        wdata,
    output logic [31:0]        rdata,
    input  logic [NUM_SRC-1:0] irq_src,
    output logic [NUM_CPU-1:0] cpu_irq
);

    localparam int unsigned     PC_N  = LOCAL_LAST + 1;
    localparam int unsigned     SRC_W = $clog2(NUM_SRC);
    localparam logic [ID_W-1:0] CNT   = ID_W'(NUM_SRC);

    typedef struct packed {
        logic [NUM_CPU-1:0][ID_W-1:0] ack;
        logic [31:0]                  rdata;
    } top_t;

    top_t top_d, top_q;

    wr_op_e                          op;
    logic [SRC_W-1:0]                idx;
    logic                            rt_hit;
    logic [SRC_W-1:0]                rt_idx;
    logic [NUM_SRC-1:0]              gen_en;
    logic [NUM_CPU-1:0][PC_N-1:0]    mask;
    logic [NUM_SRC-1:0][NUM_CPU-1:0] route;
    logic [NUM_CPU-1:0][NUM_SRC-1:0] pend;
    logic [NUM_CPU-1:0][ID_W-1:0]    pick_id;
    logic                            unused_local;

    assign unused_local = ^gen_en[PC_N-1:0];

    mcic_decode #(.NUM_SRC(NUM_SRC)) i_decode (
        .wr_en  (wr_en),
        .addr   (addr),
        .wdata  (wdata),
        .op     (op),
        .idx    (idx),
        .rt_hit (rt_hit),
        .rt_idx (rt_idx)
    );

    mcic_state #(.NUM_SRC(NUM_SRC), .NUM_CPU(NUM_CPU), .PC_N(PC_N)) i_state (
        .clk      (clk),
        .rst_n    (rst_n),
        .op       (op),
        .idx      (idx),
        .wr_cpu   (acc_cpu),
        .rt_wdata (wdata[NUM_CPU-1:0]),
        .gen_en   (gen_en),
        .mask     (mask),
        .route    (route)
    );

    for (genvar c = 0; c < NUM_CPU; c++) begin : g_cpu
        for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
            if (s < PC_N) begin : g_local
                assign pend[c][s] = irq_src[s] & ~mask[c][s];
            end else begin : g_shared
                assign pend[c][s] = irq_src[s] & gen_en[s] & route[s][c];
            end
        end

        mcic_pick #(.NUM_SRC(NUM_SRC)) i_pick (
            .pend (pend[c]),
            .id   (pick_id[c])
        );

        assign cpu_irq[c] = (top_q.ack[c] != SPURIOUS_ID);
    end

    always_comb begin
        top_d       = top_q;
        top_d.ack   = pick_id;
        top_d.rdata = '0;
        if (rd_en) begin
            case (addr)
                OFS_INFO: top_d.rdata[11:2]     = CNT;
                OFS_ACK:  top_d.rdata[ID_W-1:0] = top_q.ack[acc_cpu];
                default: begin
                    if (rt_hit) begin
                        top_d.rdata[NUM_CPU-1:0] = route[rt_idx];
                    end
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            top_q.ack   <= {NUM_CPU{SPURIOUS_ID}};
            top_q.rdata <= '0;
        end else begin
            top_q <= top_d;
        end
    end

    assign rdata = top_q.rdata;

endmodule

// File: rtl/mcic_chk.sv
module mcic_chk
    import mcic_pkg::*;
#(
    parameter int unsigned NUM_SRC = 64,
    parameter int unsigned NUM_CPU = 4
) (
    input logic               clk,
    input logic               rst_n,
    input logic               rd_en,
    input logic [11:0]        addr,
    input logic [31:0]        rdata,
    input logic [NUM_SRC-1:0] irq_src,
    input logic [NUM_CPU-1:0] cpu_irq
);

    localparam logic [ID_W-1:0] LIM = ID_W'(NUM_SRC);

    logic [1:0]         up_q;
    logic [NUM_SRC-1:0] src_q1, src_q2, src_sh;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            up_q   <= '0;
            src_q1 <= '0;
            src_q2 <= '0;
        end else begin
            if (up_q != 2'd3) up_q <= up_q + 2'd1;
            src_q1 <= irq_src;
            src_q2 <= src_q1;
        end
    end

    assign src_sh = src_q2 >> rdata[ID_W-1:0];

    // R2
    info_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (up_q == 2'd3 && $past(rd_en) && $past(addr) == OFS_INFO)
        |-> rdata == (32'(NUM_SRC) << 2));

    // R7
    ack_format_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (up_q == 2'd3 && $past(rd_en) && $past(addr) == OFS_ACK)
        |-> (rdata[31:ID_W] == '0) &&
            (rdata[ID_W-1:0] == SPURIOUS_ID || rdata[ID_W-1:0] < LIM));

    // R7
    ack_live_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (up_q == 2'd3 && $past(rd_en) && $past(addr) == OFS_ACK &&
         rdata[ID_W-1:0] != SPURIOUS_ID)
        |-> src_sh[0]);

    // R10
    quiet_inputs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (up_q == 2'd3 && $past(irq_src) == '0) |-> cpu_irq == '0);

endmodule

bind mcic_top mcic_chk #(.NUM_SRC(NUM_SRC), .NUM_CPU(NUM_CPU)) i_mcic_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .rd_en   (rd_en),
    .addr    (addr),
    .rdata   (rdata),
    .irq_src (irq_src),
    .cpu_irq (cpu_irq)
);

// File: tb/test_mcic_top.sv
module test_mcic_top;

    localparam int NS = 64;
    localparam int NC = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic          rd_en = 1'b0;
    logic [11:0]   addr = '0;
    logic [1:0]    acc_cpu = '0;
    logic [31:0]   wdata = '0;
    logic [NS-1:0] irq_src = '0;
    logic [31:0]   rdata;
    logic [NC-1:0] cpu_irq;

    int  checks = 0;
    int  errors = 0;
    bit  done = 1'b0;

    typedef struct {
        logic [31:0] exp;
        string       tag;
    } item_t;

    item_t sb[$];
    logic  took = 1'b0;

    always #4 clk = ~clk;

    mcic_top #(.NUM_SRC(NS), .NUM_CPU(NC)) i_mcic_top (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .rd_en   (rd_en),
        .addr    (addr),
        .acc_cpu (acc_cpu),
        .wdata   (wdata),
        .rdata   (rdata),
        .irq_src (irq_src),
        .cpu_irq (cpu_irq)
    );

    always @(posedge clk) took <= rd_en;

    // Monitor: compares each sampled read with the oldest expected word
    always @(negedge clk) begin
        if (took) begin
            item_t it;
            checks++;
            if (sb.size() == 0) begin
                errors++;
                $display("FAIL scoreboard: actual %h expected none", rdata);
            end else begin
                it = sb.pop_front();
                if (rdata !== it.exp) begin
                    errors++;
                    $display("FAIL %s: actual %h expected %h", it.tag, rdata, it.exp);
                end
            end
        end
    end

    task automatic wr(input logic [11:0] a, input logic [1:0] cpu, input logic [31:0] d);
        @(negedge clk);
        addr = a; acc_cpu = cpu; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, input logic [1:0] cpu, input logic [31:0] e,
                      input string tag);
        item_t it;
        @(negedge clk);
        addr = a; acc_cpu = cpu; rd_en = 1'b1;
        it.exp = e; it.tag = tag;
        sb.push_back(it);
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic chk_irq(input logic [NC-1:0] e, input string tag);
        checks++;
        if (cpu_irq !== e) begin
            errors++;
            $display("FAIL %s: actual %b expected %b", tag, cpu_irq, e);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // Reset state
        chk_irq(4'b0000, "R1 outputs low");
        for (int c = 0; c < NC; c++) rd(12'h044, 2'(c), 32'h3FF, "R1 ack spurious");
        rd(12'h000, 2'd0, 32'h100, "R2 source count");

        // Private source 5: masked out of reset
        irq_src[5] = 1'b1;
        step();
        chk_irq(4'b0000, "R1 masks set");
        wr(12'h04C, 2'd1, 32'd5);
        chk_irq(4'b0000, "R9 write edge not yet visible");
        step();
        chk_irq(4'b0010, "R4 unmask cpu1 / R8");
        rd(12'h044, 2'd1, 32'd5, "R7 ack cpu1");
        rd(12'h044, 2'd0, 32'h3FF, "R4 cpu0 untouched");

        // Enable and routing writes do not reach a private source
        wr(12'h034, 2'd1, 32'd5);
        wr(12'h114, 2'd0, 32'h0);
        step();
        chk_irq(4'b0010, "R5 private ignores enable/route");

        // Lowest index wins, and levels are not latched
        wr(12'h04C, 2'd1, 32'd3);
        irq_src[3] = 1'b1;
        rd(12'h044, 2'd1, 32'd3, "R7 lowest wins");
        irq_src[3] = 1'b0;
        rd(12'h044, 2'd1, 32'd5, "R10 fallen source gone");
        irq_src[5] = 1'b0;
        chk_irq(4'b0010, "R9 input not yet visible");
        step();
        chk_irq(4'b0000, "R10 level drop");
        irq_src[5] = 1'b1;
        step();

        // Shared source 40
        irq_src[40] = 1'b1;
        step();
        chk_irq(4'b0010, "R6 unrouted shared");
        wr(12'h1A0, 2'd0, 32'hFFFF_FFF4);
        step();
        chk_irq(4'b0010, "R6 routed but disabled");
        rd(12'h1A0, 2'd3, 32'h4, "R6 route readback");
        wr(12'h030, 2'd0, 32'd40);
        step();
        chk_irq(4'b0110, "R3 enable shared");
        rd(12'h044, 2'd2, 32'd40, "R3 ack cpu2");

        // Ignored writes
        wr(12'h030, 2'd0, 32'd64);
        wr(12'h048, 2'd2, 32'd40);
        step();
        chk_irq(4'b0110, "R4 shared index mask ignored / R3 range");
        rd(12'h044, 2'd2, 32'd40, "R4 shared index mask ignored");

        wr(12'h034, 2'd0, 32'd40);
        step();
        chk_irq(4'b0010, "R3 clear enable");

        // Route to two processors
        wr(12'h1A0, 2'd0, 32'h9);
        wr(12'h030, 2'd0, 32'd40);
        step();
        chk_irq(4'b1011, "R6 two targets");
        rd(12'h044, 2'd0, 32'd40, "R6 ack cpu0");
        rd(12'h044, 2'd3, 32'd40, "R6 ack cpu3");

        // Private beats shared for cpu0, then per-processor masking
        wr(12'h04C, 2'd0, 32'd5);
        rd(12'h044, 2'd0, 32'd5, "R7 private before shared");
        wr(12'h048, 2'd0, 32'd5);
        rd(12'h044, 2'd0, 32'd40, "R4 mask cpu0");
        rd(12'h044, 2'd1, 32'd5, "R4 cpu1 keeps unmask");

        // All quiet
        irq_src = '0;
        step();
        chk_irq(4'b0000, "R10 all low");
        rd(12'h044, 2'd3, 32'h3FF, "R7 spurious again");

        repeat (3) @(negedge clk);
        if (sb.size() != 0) begin
            errors++;
            $display("FAIL scoreboard: actual %0d left expected 0", sb.size());
        end
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule